// File: doc/BRIEF.md
# Channel Fault Reaction Controller

This block decides what one power channel does when a protection fault is seen. Four fault inputs come in: output overvoltage, output undervoltage, cycle current limit and LED overcurrent. A configuration bit for each input selects whether that fault is latched or retried. Every fault turns the channel off in the same cycle it appears.

A retried fault parks the controller in a wait state. A programmable cycle count runs there for undervoltage, current limit and overcurrent. Overvoltage does not use the count. The channel is restarted with a one-cycle soft-start request once the count has run out and no fault is active. A latched fault holds the channel off until software writes the enable bit to 1 again.

Writing 0 to the enable bit shuts the channel down from any state and drops any pending retry. Fault detection and the soft-start ramp are handled by other blocks.

Top module: `fault_responder`

## Requirements
- R1: After reset the controller is idle (off): `chan_on` and `ss_req` are 0.
- R2: From idle or latched, a clock edge with `en_wr`=1 and `en_wdata`=1 enters run. From that edge `chan_on` is 1 and `ss_req` is 1 for exactly one cycle. Every entry into run, including a retry restart, raises `ss_req` for one cycle.
- R3: While running, any active bit of `fault_in` drives `chan_on` to 0 in the same cycle. Bit 0 is overvoltage, bit 1 undervoltage, bit 2 current limit and bit 3 overcurrent.
- R4: A fault whose `nolatch_cfg` bit is 0 is latched. The channel stays off after the fault clears, for any number of cycles, until an enable write of 1 restarts it.
- R5: A retried fault with a timed bit (bits 1 to 3) loads the count `timer_len`=L on the edge the fault is taken. If the fault has cleared before the count runs out, the channel restarts on the L+1-th edge after that.
- R6: If a timed fault is still active on the H-th edge after it was taken, with H ≥ L, the restart is on edge H+1. That is the first edge at which the fault is gone.
- R7: A retried overvoltage fault alone does not use the count. The channel restarts on the first edge at which no fault is active.
- R8: During the wait, a timed fault bit that newly rises reloads the count to L. The restart then comes L+1 edges after the reload edge.
- R9: A latched fault wins. If latched and retried faults are active together while running, or a latched fault appears during the wait, the controller goes to the latched state.
- R10: An edge with `en_wr`=1 and `en_wdata`=0 forces idle from any state and cancels a pending retry. No restart follows without a new enable write of 1.
- R11: In idle, faults have no effect. During the wait, an enable write of 1 has no effect: the channel stays off until the normal retry.

Top module ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 1 | Value written to the channel enable bit |
| nolatch_cfg | input | 4 | Per-fault retry select; 1 means retried, 0 means latched |
| timer_len | input | TMR_W | Retry wait count in clock cycles |
| fault_in | input | 4 | Active fault flags: OV, UV, ILIM, OC in bits 0 to 3 |
| chan_on | output | 1 | Channel allowed to switch |
| ss_req | output | 1 | One-cycle soft-start request |

## Verification
Some properties are checked on every cycle. A latched state holds without an enable write. A disable write always lands in idle. A soft-start request is a single cycle and only occurs in run. No restart happens while a fault is present or the count is non-zero. A fault always masks `chan_on`. The exact restart cycle can only be shown by the bench scenarios. The bench sweeps fault type, count length and fault hold time, and compares against the closed form max(H,L)+1 or H+1. It also exercises the reload, the latched-wins priority, the cancelled retry and the ignored writes.

// File: rtl/fresp_pkg.sv
package fresp_pkg;
  localparam int NUM_FLT = 4;
  localparam int FLT_OV  = 0;
  localparam int FLT_UV  = 1;
  localparam int FLT_ILM = 2;
  localparam int FLT_OC  = 3;
  localparam logic [NUM_FLT-1:0] TIMED_MASK = 4'b1110;

  typedef enum logic [1:0] {
    ST_OFF     = 2'd0,
    ST_RUN     = 2'd1,
    ST_WAIT    = 2'd2,
    ST_LATCHED = 2'd3
  } fresp_state_e;

  function automatic logic [NUM_FLT-1:0] latched_bits(
    input logic [NUM_FLT-1:0] flt, input logic [NUM_FLT-1:0] nolatch);
    return flt & ~nolatch;
  endfunction

  function automatic logic [NUM_FLT-1:0] rising_timed(
    input logic [NUM_FLT-1:0] flt, input logic [NUM_FLT-1:0] prev);
    return flt & ~prev & TIMED_MASK;
  endfunction
endpackage

// File: rtl/fresp_classify.sv
module fresp_classify
  import fresp_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_FLT-1:0] fault_in,
  input  logic [NUM_FLT-1:0] nolatch_cfg,
  output logic               any_fault,
  output logic               latched_hit,
  output logic               timed_hit,
  output logic               new_timed
);
  logic [NUM_FLT-1:0] prev_q;
  logic [NUM_FLT-1:0] lat_v;
  logic [NUM_FLT-1:0] rise_v;
  logic [NUM_FLT-1:0] tim_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= fault_in;
  end

  assign lat_v  = latched_bits(fault_in, nolatch_cfg);
  assign rise_v = rising_timed(fault_in, prev_q);

  for (genvar i = 0; i < NUM_FLT; i++) begin : g_tim
    if (TIMED_MASK[i]) begin : g_on
      assign tim_v[i] = fault_in[i];
    end else begin : g_off
      assign tim_v[i] = 1'b0;
    end
  end

  assign any_fault   = |fault_in;
  assign latched_hit = |lat_v;
  assign timed_hit   = |tim_v;
  assign new_timed   = |rise_v;
endmodule

// File: rtl/fresp_timer.sv
module fresp_timer #(
  parameter int TMR_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TMR_W-1:0] load_val,
  input  logic             run_dn,
  output logic             cnt_zero
);
  logic [TMR_W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= load_val;
    else if (run_dn && cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/fault_responder.sv
module fault_responder
  import fresp_pkg::*;
#(
  parameter int TMR_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en_wr,
  input  logic               en_wdata,
  input  logic [NUM_FLT-1:0] nolatch_cfg,
  input  logic [TMR_W-1:0]   timer_len,
  input  logic [NUM_FLT-1:0] fault_in,
  output logic               chan_on,
  output logic               ss_req
);
  fresp_state_e state_q, state_d;
  logic any_fault, latched_hit, timed_hit, new_timed;
  logic wr_on, wr_off;
  logic tmr_load, cnt_zero, enter_run;
  logic [TMR_W-1:0] tmr_val;
  logic ss_q;

  fresp_classify u_cls (
    .clk(clk), .rst_n(rst_n), .fault_in(fault_in), .nolatch_cfg(nolatch_cfg),
    .any_fault(any_fault), .latched_hit(latched_hit),
    .timed_hit(timed_hit), .new_timed(new_timed)
  );

  assign wr_on  = en_wr &  en_wdata;
  assign wr_off = en_wr & ~en_wdata;

  always_comb begin
    state_d = state_q;
    if (wr_off) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:     if (wr_on) state_d = ST_RUN;
        ST_RUN: begin
          if (latched_hit)    state_d = ST_LATCHED;
          else if (any_fault) state_d = ST_WAIT;
        end
        ST_WAIT: begin
          if (latched_hit)                 state_d = ST_LATCHED;
          else if (cnt_zero && !any_fault) state_d = ST_RUN;
        end
        ST_LATCHED: if (wr_on) state_d = ST_RUN;
        default:    state_d = ST_OFF;
      endcase
    end
  end

  // Entry from run loads L only when a timed fault is present; a reload in wait always uses L.
  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = timer_len;
    if (state_q == ST_RUN && state_d == ST_WAIT) begin
      tmr_load = 1'b1;
      tmr_val  = timed_hit ? timer_len : '0;
    end else if (state_q == ST_WAIT && state_d == ST_WAIT && new_timed) begin
      tmr_load = 1'b1;
    end
  end

  fresp_timer #(.TMR_W(TMR_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
    .run_dn(state_q == ST_WAIT), .cnt_zero(cnt_zero)
  );

  assign enter_run = (state_d == ST_RUN) && (state_q != ST_RUN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_OFF;
      ss_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      ss_q    <= enter_run;
    end
  end

  assign chan_on = (state_q == ST_RUN) && !any_fault;
  assign ss_req  = ss_q;
endmodule

// File: rtl/fault_responder_chk.sv
module fault_responder_chk
  import fresp_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic               en_wr,
  input logic               en_wdata,
  input logic [NUM_FLT-1:0] fault_in,
  input logic               chan_on,
  input logic               ss_req,
  input fresp_state_e       state_q,
  input logic               cnt_zero
);
  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |-> (!chan_on && !ss_req));

  a_r2_ss_single: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |=> !ss_req);

  a_r2_ss_in_run: assert property (@(posedge clk) disable iff (!rst_n)
    ss_req |-> state_q == ST_RUN);

  a_r3_fault_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (|fault_in) |-> !chan_on);

  a_r4_latch_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_LATCHED && !en_wr) |=> state_q == ST_LATCHED);

  a_r5_no_early_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && !cnt_zero) |=> state_q != ST_RUN);

  a_r6_no_restart_in_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT && (|fault_in)) |=> state_q != ST_RUN);

  a_r10_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
    (en_wr && !en_wdata) |=> (state_q == ST_OFF && !chan_on));
endmodule

bind fault_responder fault_responder_chk chk_i (
  .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
  .fault_in(fault_in), .chan_on(chan_on), .ss_req(ss_req),
  .state_q(state_q), .cnt_zero(cnt_zero)
);

// File: tb/fault_responder_tb_top.sv
`timescale 1ns/1ps
module fault_responder_tb_top;
  localparam int TW = 8;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en_wr = 1'b0, en_wdata = 1'b0;
  logic [3:0] nolatch_cfg = 4'hF;
  logic [TW-1:0] timer_len = '0;
  logic [3:0] fault_in = '0;
  logic chan_on, ss_req;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  fault_responder #(.TMR_W(TW)) dut_i (
    .clk(clk), .rst_n(rst_n), .en_wr(en_wr), .en_wdata(en_wdata),
    .nolatch_cfg(nolatch_cfg), .timer_len(timer_len), .fault_in(fault_in),
    .chan_on(chan_on), .ss_req(ss_req)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wr_en(logic v);
    en_wr = 1'b1; en_wdata = v; tick(); en_wr = 1'b0; #1;
  endtask

  // Fresh start in run, ss pulse consumed.
  task automatic restart_clean();
    fault_in = '0; wr_en(1'b0); wr_en(1'b1); tick();
  endtask

  task automatic retry_case(logic [3:0] fb, int L, int H);
    int exp_edge, c;
    string tag;
    nolatch_cfg = 4'hF; timer_len = TW'(L);
    restart_clean();
    fault_in = fb; #1;
    chk("R3", chan_on, 0);
    tick();                                   // edge E0
    for (int k = 1; k <= H; k++) tick();
    fault_in = '0; #1;
    if ((fb & 4'b1110) != 0) begin
      exp_edge = ((H > L) ? H : L) + 1;
      tag = (H >= L) ? "R6" : "R5";
    end else begin
      exp_edge = H + 1;
      tag = "R7";
    end
    c = 0;
    while (!chan_on && c < 40) begin tick(); c++; end
    chk(tag, H + c, exp_edge);
    chk("R2", ss_req, 1);
    tick();
    chk("R2", ss_req, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int c;
    // R1 reset state
    #1;
    chk("R1", chan_on, 0); chk("R1", ss_req, 0);
    repeat (3) tick();
    rst_n = 1'b1; tick();
    chk("R1", chan_on, 0); chk("R1", ss_req, 0);

    // R11 faults in idle have no effect
    fault_in = 4'b1111; nolatch_cfg = 4'h0; repeat (3) tick();
    fault_in = '0; #1;
    chk("R11", chan_on, 0);
    // R2 enable from idle
    en_wr = 1; en_wdata = 1; tick(); en_wr = 0; #1;
    chk("R2", chan_on, 1); chk("R2", ss_req, 1);
    tick();
    chk("R2", ss_req, 0); chk("R2", chan_on, 1);

    // R5/R6/R7 sweep
    for (int f = 0; f < 4; f++)
      for (int L = 0; L <= 4; L++)
        for (int H = 0; H <= 5; H++)
          retry_case(4'(1 << f), L, H);
    // mixed OV+UV uses the timer
    retry_case(4'b0011, 3, 0);

    // R4 latched fault
    for (int f = 0; f < 4; f++) begin
      nolatch_cfg = ~(4'(1 << f)); timer_len = 2;
      restart_clean();
      fault_in = 4'(1 << f); tick(); fault_in = '0;
      repeat (12) tick();
      chk("R4", chan_on, 0); chk("R4", ss_req, 0);
      wr_en(1'b1);
      chk("R4", chan_on, 1); chk("R4", ss_req, 1);
    end

    // R9 simultaneous latched (UV) and retried (OV)
    nolatch_cfg = 4'b1101; timer_len = 1;
    restart_clean();
    fault_in = 4'b0011; tick(); fault_in = '0;
    repeat (8) tick();
    chk("R9", chan_on, 0);
    // R9 latched fault during wait
    nolatch_cfg = 4'b0001; timer_len = 3;
    restart_clean();
    fault_in = 4'b0001; tick(); fault_in = '0; tick();
    fault_in = 4'b1000; tick(); fault_in = '0;
    repeat (10) tick();
    chk("R9", chan_on, 0);

    // R8 reload: UV at E0, ILIM pulse on E2, L=4 -> restart at edge 7
    nolatch_cfg = 4'hF; timer_len = 4;
    restart_clean();
    fault_in = 4'b0010; tick(); fault_in = '0; #1;
    tick();                                   // E1
    fault_in = 4'b0100; tick(); fault_in = '0; #1;   // E2
    c = 2;
    while (!chan_on && c < 40) begin tick(); c++; end
    chk("R8", c, 7);

    // R10 disable during wait cancels retry
    nolatch_cfg = 4'hF; timer_len = 5;
    restart_clean();
    fault_in = 4'b0100; tick(); fault_in = '0; tick();
    wr_en(1'b0);
    c = 0;
    for (int k = 0; k < 12; k++) begin tick(); c += chan_on + ss_req; end
    chk("R10", c, 0);
    wr_en(1'b1);
    chk("R10", chan_on, 1);
    // R10 disable from run and from latched
    wr_en(1'b0); chk("R10", chan_on, 0);
    nolatch_cfg = 4'h0; restart_clean();
    fault_in = 4'b0001; tick(); fault_in = '0;
    wr_en(1'b0); wr_en(1'b1); chk("R10", chan_on, 1);

    // R11 enable write of 1 during wait is ignored, L=3
    nolatch_cfg = 4'hF; timer_len = 3;
    restart_clean();
    fault_in = 4'b1000; tick(); fault_in = '0;       // E0
    wr_en(1'b1);                                     // E1
    chk("R11", chan_on, 0); chk("R11", ss_req, 0);
    c = 1;
    while (!chan_on && c < 40) begin tick(); c++; end
    chk("R11", c, 4);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule